// File: doc/BRIEF.md
# Parallel Sampling ADC Sequencer

This block drives a 12-bit sampling converter that has a parallel output bus, an end-of-conversion flag and a selectable output coding. It runs from one synchronous system clock. It issues a start pulse of fixed width at a programmable interval, and it follows the converter's busy flag through a two-stage synchronizer. Once the flag has been seen high and then low, the block enables the converter's active-low bus drivers for two cycles and latches the word on the second cycle. It then presents the result with a one-cycle valid strobe.

The converter can return either true or inverted coding, depending on a select line that the block owns. Requested changes to that line take effect only while no conversion is in flight. The block undoes the inversion, so downstream logic always receives straight binary, or offset binary when the input range is bipolar. It also produces a sign-extended two's-complement value by flipping the MSB.

A restart request during a conversion throws that conversion away and begins a new one. A conversion whose busy flag never falls within the timeout window sets a sticky error flag, and the controller returns to idle.

The state machine has five states:
- **S_IDLE**: waits for the next start.
- **S_PULSE**: holds the start line high.
- **S_WAIT**: waits for the busy flag to fall.
- **S_ENABLE**: turns on the converter's bus drivers.
- **S_LATCH**: keeps the drivers on and captures the word.

It has eight named transitions:
- **launch** (S_IDLE→S_PULSE): run is high and the interval has elapsed.
- **pulse_end** (S_PULSE→S_WAIT): the pulse width has been reached.
- **restart** (S_WAIT→S_PULSE): restart input. This has the highest priority in S_WAIT.
- **eoc_done** (S_WAIT→S_ENABLE): the synchronized flag was seen high and is now low.
- **timeout** (S_WAIT→S_IDLE): the timeout count has been reached.
- **bus_on** (S_ENABLE→S_LATCH).
- **capture** (S_LATCH→S_IDLE).
- **hold** (every state stays put otherwise).

Top module: `adc_seq_ctrl`

## Requirements
- R1: In reset and right after it: start_o=0, oe_n_o=1, sample_valid_o=0, timeout_err_o=0, coding_o=1, sample_o=0, signed_o=0.
- R2: Each start pulse is high for exactly PULSE_CYC cycles. While run_i is high and every conversion finishes in time, successive start rising edges are exactly RATE_CYC cycles apart. No start pulse is issued while run_i is low.
- R3: oe_n_o goes low only after the synchronized EOC has been seen high and then low. It stays low for exactly two cycles per captured conversion, and it is never low while EOC is high.
- R4: Each completed conversion gives exactly one sample_valid_o pulse, one cycle long. sample_o equals adc_data_i when coding_o=1 and ~adc_data_i when coding_o=0, both sampled in the last enable cycle.
- R5: signed_o (16 bits) is sample_o − 2048 sign-extended when bipolar_i=1, and sample_o zero-extended when bipolar_i=0.
- R6: coding_o copies coding_req_i only while the controller is idle. It never changes during a conversion, so it never changes while EOC is high.
- R7: When restart_i is high while the controller waits for EOC, a new start pulse begins on the next cycle. The interrupted conversion produces no valid pulse; only the restarted one does.
- R8: If EOC has not fallen TIMEOUT_CYC cycles after a start, timeout_err_o is set and the controller returns to idle without a valid pulse. The flag stays set until reset.
- R9: adc_data_i[11] carries the converter's MSB and adc_data_i[0] its LSB. A result of 0x800 is midscale, giving signed_o=0 in bipolar mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables periodic conversions |
| bipolar_i | input | 1 | Selects bipolar interpretation for signed_o |
| coding_req_i | input | 1 | Requested coding select (1 = true coding) |
| restart_i | input | 1 | Abort the current conversion and start again |
| eoc_i | input | 1 | Asynchronous busy flag from the converter |
| adc_data_i | input | 12 | Converter parallel bus, bit 11 = MSB |
| start_o | output | 1 | Start-convert pulse |
| oe_n_o | output | 1 | Active-low output enable to the converter |
| coding_o | output | 1 | Coding select line to the converter |
| sample_o | output | 12 | Normalized straight/offset-binary result |
| signed_o | output | 16 | Sign-extended two's-complement result |
| sample_valid_o | output | 1 | One-cycle strobe for a new result |
| timeout_err_o | output | 1 | Sticky timeout flag |

## Verification
The assertions watch, on every cycle, the following:
- the pulse width;
- the absence of starts while idle with run low;
- the rule that bus enable follows a seen-high-then-low busy flag;
- the single-cycle valid strobe;
- the freeze of the coding line outside idle;
- the restart response;
- the stickiness of the error flag.

Some behaviours show only in the bench's scenarios, because they need a converter model that encodes a chosen value under the current coding. These are the end-to-end value path over all 4096 codes and all four codings, the exact start spacing, the discarding of an aborted result, and the timeout followed by recovery.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PULSE  = 3'd1,
        S_WAIT   = 3'd2,
        S_ENABLE = 3'd3,
        S_LATCH  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_since_start.sv
module adc_since_start #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    // Saturating elapsed-cycle counter; resets saturated so the first launch is immediate.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 count_o <= '1;
        else if (clear_i)           count_o <= '0;
        else if (count_o != '1)     count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/adc_code_norm.sv
module adc_code_norm #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 16
) (
    input  logic              [DATA_W-1:0] raw_i,
    input  logic                           coding_i,
    input  logic                           bipolar_i,
    output logic              [DATA_W-1:0] straight_o,
    output logic              [OUT_W-1:0]  signed_o
);
    localparam int EXT_W = OUT_W - DATA_W;

    logic [DATA_W-1:0] twos;

    always_comb begin
        straight_o = coding_i ? raw_i : ~raw_i;
        twos       = straight_o;
        twos[DATA_W-1] = ~straight_o[DATA_W-1];
        if (bipolar_i) signed_o = {{EXT_W{twos[DATA_W-1]}}, twos};
        else           signed_o = {{EXT_W{1'b0}}, straight_o};
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int OUT_W       = 16,
    parameter int PULSE_CYC   = 15,
    parameter int RATE_CYC    = 100,
    parameter int TIMEOUT_CYC = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              bipolar_i,
    input  logic              coding_req_i,
    input  logic              restart_i,
    input  logic              eoc_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              start_o,
    output logic              oe_n_o,
    output logic              coding_o,
    output logic [DATA_W-1:0] sample_o,
    output logic [OUT_W-1:0]  signed_o,
    output logic              sample_valid_o,
    output logic              timeout_err_o
);
    localparam int LIM_A     = (RATE_CYC > TIMEOUT_CYC) ? RATE_CYC : TIMEOUT_CYC;
    localparam int LIMIT_MAX = (LIM_A > PULSE_CYC) ? LIM_A : PULSE_CYC;
    localparam int CNT_W     = $clog2(LIMIT_MAX + 1);

    seq_state_t        state_q, state_d;
    logic              start_evt, timeout_evt;
    logic [CNT_W-1:0]  cnt;
    logic              eoc_s, seen_high_q, eoc_fell;
    logic              pulse_done, rate_due, timed_out;
    logic [DATA_W-1:0] norm_straight;
    logic [OUT_W-1:0]  norm_signed;

    adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(eoc_i), .sync_o(eoc_s)
    );

    adc_since_start #(.CNT_W(CNT_W)) u_elapsed (
        .clk(clk), .rst_n(rst_n), .clear_i(start_evt), .count_o(cnt)
    );

    adc_code_norm #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_norm (
        .raw_i(adc_data_i), .coding_i(coding_o), .bipolar_i(bipolar_i),
        .straight_o(norm_straight), .signed_o(norm_signed)
    );

    assign pulse_done = (cnt >= CNT_W'(PULSE_CYC - 1));
    assign rate_due   = (cnt >= CNT_W'(RATE_CYC - 1));
    assign timed_out  = (cnt >= CNT_W'(TIMEOUT_CYC - 1));
    assign eoc_fell   = seen_high_q && !eoc_s;

    // Next-state logic with named transitions.
    always_comb begin
        state_d     = state_q;
        start_evt   = 1'b0;
        timeout_evt = 1'b0;
        unique case (state_q)
            S_IDLE: if (run_i && rate_due) begin            // launch
                state_d   = S_PULSE;
                start_evt = 1'b1;
            end
            S_PULSE: if (pulse_done) state_d = S_WAIT;      // pulse_end
            S_WAIT: begin
                if (restart_i) begin                        // restart
                    state_d   = S_PULSE;
                    start_evt = 1'b1;
                end else if (eoc_fell) begin                // eoc_done
                    state_d = S_ENABLE;
                end else if (timed_out) begin               // timeout
                    state_d     = S_IDLE;
                    timeout_evt = 1'b1;
                end
            end
            S_ENABLE: state_d = S_LATCH;                    // bus_on
            S_LATCH:  state_d = S_IDLE;                     // capture
            default:  state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_high_q    <= 1'b0;
            coding_o       <= 1'b1;
            sample_o       <= '0;
            signed_o       <= '0;
            sample_valid_o <= 1'b0;
            timeout_err_o  <= 1'b0;
        end else begin
            seen_high_q    <= start_evt ? 1'b0 : (seen_high_q | eoc_s);
            sample_valid_o <= (state_q == S_LATCH);
            if (state_q == S_IDLE) coding_o <= coding_req_i;
            if (state_q == S_LATCH) begin
                sample_o <= norm_straight;
                signed_o <= norm_signed;
            end
            if (timeout_evt) timeout_err_o <= 1'b1;
        end
    end

    always_comb begin
        start_o = (state_q == S_PULSE);
        oe_n_o  = !((state_q == S_ENABLE) || (state_q == S_LATCH));
    end

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_o) |-> ($past(cnt) == CNT_W'(PULSE_CYC - 1)));
    p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && state_q == S_IDLE) |=> !start_o);
    p_oe_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n_o) |-> $past(seen_high_q && !eoc_s));
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_o |=> !sample_valid_o);
    p_valid_after_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_valid_o) |-> $past(!oe_n_o));
    p_coding_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != S_IDLE) |-> $stable(coding_o));
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && restart_i) |=> (start_o && !sample_valid_o));
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o |=> timeout_err_o);
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 3;
    localparam int RATE       = 24;
    localparam int TMO        = 20;
    localparam int CONV       = 8;
    localparam int WD_LIMIT   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0, bipolar = 1'b0, coding_req = 1'b1, restart = 1'b0;
    logic        eoc;
    logic [11:0] bus;
    logic        start_o, oe_n, coding_o, valid, err;
    logic [11:0] sample;
    logic [15:0] sgn;

    int total = 0, bad = 0, cyc = 0;
    int start_rises = 0, valid_cnt = 0, last_rise = 0, prev_rise = 0, last_width = 0;
    int oe_low_run = 0, oe_eoc_overlap = 0;
    bit done = 0, stuck = 0;
    logic [11:0] next_val = '0, code_v = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(.PULSE_CYC(PULSE), .RATE_CYC(RATE), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .bipolar_i(bipolar),
        .coding_req_i(coding_req), .restart_i(restart), .eoc_i(eoc),
        .adc_data_i(bus), .start_o(start_o), .oe_n_o(oe_n), .coding_o(coding_o),
        .sample_o(sample), .signed_o(sgn), .sample_valid_o(valid),
        .timeout_err_o(err)
    );

    // Converter model output: encoded by the current coding line, garbage when not enabled.
    logic [11:0] enc;
    assign enc = coding_o ? code_v : ~code_v;
    assign bus = oe_n ? ~enc : enc;

    // Converter model: busy flag timing, stepped on the falling clock edge.
    initial begin
        int left = 0;
        bit sp = 0;
        eoc = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                eoc = 1'b0; left = 0; sp = 0;
            end else begin
                if (start_o && !sp) begin
                    eoc = 1'b1; left = CONV; code_v = next_val;
                end else if (eoc && !stuck) begin
                    if (left > 1) left = left - 1;
                    else begin eoc = 1'b0; left = 0; end
                end
                sp = start_o;
            end
        end
    end

    // Port monitor.
    initial begin
        bit sp = 0;
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            if (start_o && !sp) begin
                start_rises = start_rises + 1;
                prev_rise = last_rise; last_rise = cyc; oe_low_run = 0;
            end
            if (!start_o && sp) last_width = cyc - last_rise;
            if (!oe_n) oe_low_run = oe_low_run + 1;
            if (!oe_n && eoc) oe_eoc_overlap = oe_eoc_overlap + 1;
            if (valid) valid_cnt = valid_cnt + 1;
            sp = start_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (valid) return;
        end
        check(1'b0, "valid timeout", 0, 1);
    endtask

    task automatic check_value(input int v, input bit bip);
        int es;
        es = bip ? (v - 2048) : v;
        check(sample == 12'(v), "R4/R9 sample", int'(sample), v);
        check($signed(sgn) == 16'(es), "R5 signed", int'($signed(sgn)), es);
    endtask

    task automatic sweep(input bit bip, input bit cod, input int step);
        bipolar = bip; coding_req = cod;
        for (int v = 0; v < 4096; v += step) begin
            next_val = 12'(v);
            wait_valid();
            check_value(v, bip);
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset state
        check(start_o == 0 && oe_n == 1 && valid == 0 && err == 0, "R1 ctrl", int'({start_o, oe_n, valid, err}), 4);
        check(coding_o == 1 && sample == 0 && sgn == 0, "R1 data", int'(sample), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_o == 0 && oe_n == 1 && coding_o == 1 && err == 0, "R1 after release", int'(start_o), 0);

        // R2: run low means no starts
        repeat (40) @(negedge clk);
        check(start_rises == 0, "R2 no start while run low", start_rises, 0);

        // R2/R3: width, spacing and enable length
        next_val = 12'h123;
        run = 1'b1;
        wait_valid();
        check_value(12'h123, 0);
        check(oe_low_run == 2, "R3 enable cycles", oe_low_run, 2);
        next_val = 12'h456;
        wait_valid();
        check(last_width == PULSE, "R2 pulse width", last_width, PULSE);
        check(last_rise - prev_rise == RATE, "R2 spacing", last_rise - prev_rise, RATE);
        check_value(12'h456, 0);

        // R4/R5/R9: full sweep in complementary offset binary, sampled sweeps for the rest
        sweep(1'b1, 1'b0, 1);
        sweep(1'b0, 1'b1, 64);
        sweep(1'b0, 1'b0, 64);
        sweep(1'b1, 1'b1, 64);
        next_val = 12'h800; bipolar = 1'b1;
        wait_valid();
        check($signed(sgn) == 0, "R9 midscale", int'($signed(sgn)), 0);

        // R6: coding request while busy is held off
        begin
            bit held = 1;
            next_val = 12'h3C5;
            while (!eoc) @(negedge clk);
            coding_req = 1'b0;
            while (eoc) begin
                if (coding_o != 1'b1) held = 0;
                @(negedge clk);
            end
            check(held, "R6 coding frozen while busy", int'(held), 1);
            wait_valid();
            check_value(12'h3C5, 1);
            @(negedge clk);
            check(coding_o == 1'b0, "R6 coding applied in idle", int'(coding_o), 0);
        end

        // R7: restart discards the partial result
        begin
            int vb, rb;
            vb = valid_cnt; rb = start_rises;
            next_val = 12'hABC;
            while (start_rises == rb) @(negedge clk);
            next_val = 12'h5E1;
            while (!eoc) @(negedge clk);
            repeat (4) @(negedge clk);
            restart = 1'b1;
            @(negedge clk);
            restart = 1'b0;
            check(start_o == 1'b1, "R7 restart pulse", int'(start_o), 1);
            wait_valid();
            check_value(12'h5E1, 1);
            check(valid_cnt == vb + 1, "R7 single valid", valid_cnt - vb, 1);
            check(start_rises == rb + 2, "R7 start count", start_rises - rb, 2);
        end

        // R8: timeout, then recovery with sticky flag
        begin
            int vb;
            vb = valid_cnt;
            stuck = 1;
            for (int i = 0; i < 60 && !err; i++) @(negedge clk);
            check(err == 1'b1, "R8 timeout flag", int'(err), 1);
            check(valid_cnt == vb, "R8 no valid on timeout", valid_cnt - vb, 0);
            stuck = 0;
            next_val = 12'h0F0;
            wait_valid();
            check_value(12'h0F0, 1);
            check(err == 1'b1, "R8 sticky", int'(err), 1);
        end

        // R2: stop running
        begin
            int rb;
            run = 1'b0;
            rb = start_rises;
            repeat (60) @(negedge clk);
            check(start_rises == rb, "R2 stopped", start_rises - rb, 0);
        end
        check(oe_eoc_overlap == 0, "R3 enable vs busy", oe_eoc_overlap, 0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        while (cyc < WD_LIMIT) @(negedge clk);
        if (!done) begin
            done = 1;
            total = total + 1; bad = bad + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule